// File: doc/BRIEF.md
# Asynchronous SRAM Byte-Lane Controller

This block sits between a synchronous request port and an external asynchronous static RAM. The RAM is built from four byte-wide banks that share one 17-bit address bus. Each bank has its own active-low chip select and write strobe, and one active-low output enable is common to all banks. The controller accepts one read or write at a time on a valid/ready handshake. It turns each request into a strobe sequence whose phase lengths are whole clock cycles, derived from the clock period and the RAM's minimum timing values, which are all parameters.

A mode input, sampled when a request is accepted, sets the logical organisation:
- 32-bit words, 128K deep;
- 16-bit words, 256K deep;
- 8-bit words, 512K deep.

In the narrower modes the lowest logical address bits choose the banks, and the bits above them form the physical address. Write data is copied onto the chosen lanes. Read data is taken from the chosen lanes, registered, and returned zero-extended, together with a one-cycle done pulse.

The data bus uses separate in and out vectors with a drive enable, which a pad ring can combine into a tri-state bus. With the default 5 ns clock, a write is one setup cycle followed by three strobe cycles. A read holds output enable low for three cycles, then keeps the bus idle for two turnaround cycles.

Top module: `sram_lane_ctrl`

## Requirements
- R1: Coming out of reset, req_ready is high, every mem_cs_n and mem_we_n bit is high, mem_oe_n is high, mem_dq_oe is low and rsp_done is low.
- R2: With org_mode 2'b00 (32-bit), mem_addr equals req_addr[16:0], a read pulls all four chip selects low, and lane n carries bits 8n+7..8n of the word in both directions.
- R3: A write in 32-bit mode pulses the write strobe only on lanes whose req_be bit is 1. Bytes on the other lanes keep their stored values.
- R4: With org_mode 2'b01 (16-bit), req_addr[0]=0 selects lanes 0–1 and req_addr[0]=1 selects lanes 2–3, and mem_addr equals req_addr[17:1]. Writes store req_wdata[15:0] on the selected pair. Reads return that pair in bits 15:0 with bits 31:16 zero. The other lanes' chip selects stay high.
- R5: With org_mode 2'b10 or 2'b11 (8-bit), req_addr[1:0] selects one lane and mem_addr equals req_addr[18:2]. Only that lane's chip select and write strobe go low. Writes store req_wdata[7:0]. Reads return the byte in bits 7:0 with the rest zero.
- R6: A write drives the bus with chip select low and write strobe high for one cycle. It then holds the write strobe low for WP cycles, the largest of ceil(tWP/T), ceil(tDW/T) and ceil(tWC/T)−1 (3 by default). The bus stays driven and mem_addr stays stable for the whole strobe. rsp_done is high in cycle WP+2 after the accepting edge.
- R7: A read holds chip select and output enable low for RD = max(ceil(tRC/T), ceil(tOE/T)) cycles (3 by default), with write strobes high. The bus is captured at the last of those edges, and rsp_done is high with the data in cycle RD+1.
- R8: After output enable rises, the bus stays undriven and req_ready stays low for TA = ceil(tHZ/T) cycles (2 by default).
- R9: mem_dq_oe is never high while mem_oe_n is low. No write strobe is low while mem_oe_n is low. No lane's write strobe is low while its chip select is high.
- R10: rsp_done lasts exactly one cycle. req_ready is high only when no access is in progress, and then all chip selects are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| org_mode | input | 2 | Organisation: 00 32-bit, 01 16-bit, 10/11 8-bit |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle, request accepted on valid and ready |
| req_write | input | 1 | 1 write, 0 read |
| req_addr | input | 19 | Logical address |
| req_wdata | input | 32 | Write data, low bits used in narrow modes |
| req_be | input | 4 | Lane write mask, 32-bit mode only |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 32 | Registered read data, zero-extended |
| mem_addr | output | 17 | Physical address to all banks |
| mem_cs_n | output | 4 | Per-lane chip select, active low |
| mem_we_n | output | 4 | Per-lane write strobe, active low |
| mem_oe_n | output | 1 | Shared output enable, active low |
| mem_dq_out | output | 32 | Data driven toward the RAM |
| mem_dq_oe | output | 1 | Drive enable for mem_dq_out |
| mem_dq_in | input | 32 | Data returned from the RAM |

## Verification
The assertions assume that rst_n is low at time zero and is held for several clocks. They also assume that the strobe-width counters measure a RAM that sees only this controller's strobes, so nothing else may touch the bus. The stimulus keeps within these limits: it drops req_valid in the cycle after acceptance, never changes org_mode while an access is in progress, and keeps every physical address below 64 so that a small bench memory can stand in for the banks. Lanes that are not enabled for reading return a fixed 8'hA5 rather than zero, so any failure to steer the lanes or zero-extend the result shows up in the returned data.

// File: rtl/sram_lane_pkg.sv
`timescale 1ns/1ps
package sram_lane_pkg;

  typedef enum logic [1:0] {
    ORG_X32  = 2'b00,
    ORG_X16  = 2'b01,
    ORG_X8   = 2'b10,
    ORG_X8B  = 2'b11
  } org_e;

  typedef enum logic [2:0] {
    PH_IDLE    = 3'd0,
    PH_WSETUP  = 3'd1,
    PH_WSTROBE = 3'd2,
    PH_RACCESS = 3'd3,
    PH_TURN    = 3'd4
  } phase_e;

  function automatic int unsigned cyc_of(input int unsigned t_ps, input int unsigned clk_ps);
    return (t_ps + clk_ps - 1) / clk_ps;
  endfunction

  function automatic int unsigned umax(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

  // setup cycle counts toward the write cycle time, hence the minus one
  function automatic int unsigned strobe_cycles(input int unsigned clk_ps, input int unsigned wp_ps,
                                                input int unsigned dw_ps, input int unsigned wc_ps);
    int unsigned n;
    n = umax(cyc_of(wp_ps, clk_ps), cyc_of(dw_ps, clk_ps));
    if (cyc_of(wc_ps, clk_ps) > 1) n = umax(n, cyc_of(wc_ps, clk_ps) - 1);
    return umax(n, 1);
  endfunction

  function automatic int unsigned access_cycles(input int unsigned clk_ps, input int unsigned rc_ps,
                                                input int unsigned oe_ps);
    return umax(umax(cyc_of(rc_ps, clk_ps), cyc_of(oe_ps, clk_ps)), 1);
  endfunction

  function automatic int unsigned turn_cycles(input int unsigned clk_ps, input int unsigned hz_ps);
    return umax(cyc_of(hz_ps, clk_ps), 1);
  endfunction

endpackage

// File: rtl/sram_lane_decode.sv
`timescale 1ns/1ps
module sram_lane_decode
  import sram_lane_pkg::*;
#(
  parameter int LANES   = 4,
  parameter int LANE_W  = 8,
  parameter int PADDR_W = 17,
  localparam int DATA_W  = LANES * LANE_W,
  localparam int SEL_W   = $clog2(LANES),
  localparam int LADDR_W = PADDR_W + SEL_W,
  localparam int HALF    = LANES / 2
) (
  input  org_e                org,
  input  logic [LADDR_W-1:0]  laddr,
  input  logic [DATA_W-1:0]   wdata,
  input  logic [LANES-1:0]    be,
  output logic [PADDR_W-1:0]  paddr,
  output logic [LANES-1:0]    lane_sel,
  output logic [LANES-1:0]    lane_wr,
  output logic [DATA_W-1:0]   lane_wdata
);

  always_comb begin
    case (org)
      ORG_X32: paddr = laddr[PADDR_W-1:0];
      ORG_X16: paddr = laddr[PADDR_W:1];
      default: paddr = laddr[LADDR_W-1:SEL_W];
    endcase
  end

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    localparam logic             UPPER = (l >= HALF);
    localparam logic [SEL_W-1:0] IDX   = SEL_W'(l);
    localparam int               SUB   = l % HALF;
    logic              sel_c;
    logic              wr_c;
    logic [LANE_W-1:0] dat_c;

    always_comb begin
      case (org)
        ORG_X32: begin
          sel_c = 1'b1;
          wr_c  = be[l];
          dat_c = wdata[l*LANE_W +: LANE_W];
        end
        ORG_X16: begin
          sel_c = (laddr[0] == UPPER);
          wr_c  = sel_c;
          dat_c = wdata[SUB*LANE_W +: LANE_W];
        end
        default: begin
          sel_c = (laddr[SEL_W-1:0] == IDX);
          wr_c  = sel_c;
          dat_c = wdata[LANE_W-1:0];
        end
      endcase
    end

    assign lane_sel[l]                    = sel_c;
    assign lane_wr[l]                     = wr_c;
    assign lane_wdata[l*LANE_W +: LANE_W] = dat_c;
  end

endmodule

// File: rtl/sram_lane_seq.sv
`timescale 1ns/1ps
module sram_lane_seq
  import sram_lane_pkg::*;
#(
  parameter int unsigned CLK_PS  = 5000,
  parameter int unsigned T_WC_PS = 15000,
  parameter int unsigned T_WP_PS = 13000,
  parameter int unsigned T_DW_PS = 10000,
  parameter int unsigned T_RC_PS = 15000,
  parameter int unsigned T_OE_PS = 10000,
  parameter int unsigned T_HZ_PS = 8000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic start_wr,
  output logic idle,
  output logic cs_act,
  output logic we_act,
  output logic oe_act,
  output logic drive,
  output logic capture,
  output logic done
);

  localparam int unsigned WP_CYC  = strobe_cycles(CLK_PS, T_WP_PS, T_DW_PS, T_WC_PS);
  localparam int unsigned RD_CYC  = access_cycles(CLK_PS, T_RC_PS, T_OE_PS);
  localparam int unsigned TA_CYC  = turn_cycles(CLK_PS, T_HZ_PS);
  localparam int unsigned CNT_MAX = umax(umax(WP_CYC, RD_CYC), TA_CYC);
  localparam int          CNT_W   = (CNT_MAX > 1) ? $clog2(CNT_MAX) : 1;

  phase_e           ph_q, ph_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             done_q, done_d;
  logic             last;

  assign last = (cnt_q == '0);

  always_comb begin
    ph_d   = ph_q;
    cnt_d  = cnt_q;
    done_d = 1'b0;
    case (ph_q)
      PH_IDLE: begin
        if (start) begin
          ph_d  = start_wr ? PH_WSETUP : PH_RACCESS;
          cnt_d = start_wr ? '0 : CNT_W'(RD_CYC - 1);
        end
      end
      PH_WSETUP: begin
        ph_d  = PH_WSTROBE;
        cnt_d = CNT_W'(WP_CYC - 1);
      end
      PH_WSTROBE: begin
        if (last) begin
          ph_d   = PH_IDLE;
          done_d = 1'b1;
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      PH_RACCESS: begin
        if (last) begin
          ph_d   = PH_TURN;
          cnt_d  = CNT_W'(TA_CYC - 1);
          done_d = 1'b1;
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      PH_TURN: begin
        if (last) ph_d = PH_IDLE;
        else      cnt_d = cnt_q - 1'b1;
      end
      default: ph_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q   <= PH_IDLE;
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else begin
      ph_q   <= ph_d;
      cnt_q  <= cnt_d;
      done_q <= done_d;
    end
  end

  assign idle    = (ph_q == PH_IDLE);
  assign cs_act  = (ph_q == PH_WSETUP) || (ph_q == PH_WSTROBE) || (ph_q == PH_RACCESS);
  assign we_act  = (ph_q == PH_WSTROBE);
  assign oe_act  = (ph_q == PH_RACCESS);
  assign drive   = (ph_q == PH_WSETUP) || (ph_q == PH_WSTROBE);
  assign capture = (ph_q == PH_RACCESS) && last;
  assign done    = done_q;

endmodule

// File: rtl/sram_lane_rdcap.sv
`timescale 1ns/1ps
module sram_lane_rdcap
  import sram_lane_pkg::*;
#(
  parameter int LANES  = 4,
  parameter int LANE_W = 8,
  localparam int DATA_W = LANES * LANE_W,
  localparam int HALF_W = DATA_W / 2,
  localparam int SEL_W  = $clog2(LANES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              capture,
  input  org_e              org,
  input  logic [SEL_W-1:0]  lsb,
  input  logic [DATA_W-1:0] dq_in,
  output logic [DATA_W-1:0] rdata_q
);

  logic [DATA_W-1:0] rd_d;

  always_comb begin
    rd_d = '0;
    case (org)
      ORG_X32: rd_d = dq_in;
      ORG_X16: rd_d[HALF_W-1:0] = lsb[0] ? dq_in[DATA_W-1:HALF_W] : dq_in[HALF_W-1:0];
      default: rd_d[LANE_W-1:0] = dq_in[lsb*LANE_W +: LANE_W];
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       rdata_q <= '0;
    else if (capture) rdata_q <= rd_d;
  end

endmodule

// File: rtl/sram_lane_ctrl.sv
`timescale 1ns/1ps
module sram_lane_ctrl
  import sram_lane_pkg::*;
#(
  parameter int LANES   = 4,
  parameter int LANE_W  = 8,
  parameter int PADDR_W = 17,
  parameter int unsigned CLK_PS  = 5000,
  parameter int unsigned T_WC_PS = 15000,
  parameter int unsigned T_WP_PS = 13000,
  parameter int unsigned T_DW_PS = 10000,
  parameter int unsigned T_RC_PS = 15000,
  parameter int unsigned T_OE_PS = 10000,
  parameter int unsigned T_HZ_PS = 8000,
  localparam int DATA_W  = LANES * LANE_W,
  localparam int SEL_W   = $clog2(LANES),
  localparam int LADDR_W = PADDR_W + SEL_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [1:0]         org_mode,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic               req_write,
  input  logic [LADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0]  req_wdata,
  input  logic [LANES-1:0]   req_be,
  output logic               rsp_done,
  output logic [DATA_W-1:0]  rsp_rdata,
  output logic [PADDR_W-1:0] mem_addr,
  output logic [LANES-1:0]   mem_cs_n,
  output logic [LANES-1:0]   mem_we_n,
  output logic               mem_oe_n,
  output logic [DATA_W-1:0]  mem_dq_out,
  output logic               mem_dq_oe,
  input  logic [DATA_W-1:0]  mem_dq_in
);

  // reset: asserted at once, released after two clock edges
  logic rst_meta_q, rst_sync_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  org_e               org_in;
  logic [PADDR_W-1:0] dec_paddr;
  logic [LANES-1:0]   dec_sel, dec_wr;
  logic [DATA_W-1:0]  dec_wdata;

  assign org_in = org_e'(org_mode);

  sram_lane_decode #(.LANES(LANES), .LANE_W(LANE_W), .PADDR_W(PADDR_W)) decode_i (
    .org        (org_in),
    .laddr      (req_addr),
    .wdata      (req_wdata),
    .be         (req_be),
    .paddr      (dec_paddr),
    .lane_sel   (dec_sel),
    .lane_wr    (dec_wr),
    .lane_wdata (dec_wdata)
  );

  logic idle, cs_act, we_act, oe_act, drive, capture, accept;

  assign req_ready = idle & rst_sync_q;
  assign accept    = req_valid & req_ready;

  sram_lane_seq #(
    .CLK_PS(CLK_PS), .T_WC_PS(T_WC_PS), .T_WP_PS(T_WP_PS), .T_DW_PS(T_DW_PS),
    .T_RC_PS(T_RC_PS), .T_OE_PS(T_OE_PS), .T_HZ_PS(T_HZ_PS)
  ) seq_i (
    .clk      (clk),
    .rst_n    (rst_sync_q),
    .start    (accept),
    .start_wr (req_write),
    .idle     (idle),
    .cs_act   (cs_act),
    .we_act   (we_act),
    .oe_act   (oe_act),
    .drive    (drive),
    .capture  (capture),
    .done     (rsp_done)
  );

  // request holding registers, loaded on accept
  logic [PADDR_W-1:0] paddr_q;
  logic [LANES-1:0]   sel_q, wmask_q;
  logic [DATA_W-1:0]  wdata_q;
  org_e               org_q;
  logic [SEL_W-1:0]   lsb_q;

  always_ff @(posedge clk or negedge rst_sync_q) begin
    if (!rst_sync_q) begin
      paddr_q <= '0;
      sel_q   <= '0;
      wmask_q <= '0;
      wdata_q <= '0;
      org_q   <= ORG_X32;
      lsb_q   <= '0;
    end else if (accept) begin
      paddr_q <= dec_paddr;
      sel_q   <= dec_sel;
      wmask_q <= dec_wr & {LANES{req_write}};
      wdata_q <= dec_wdata;
      org_q   <= org_in;
      lsb_q   <= req_addr[SEL_W-1:0];
    end
  end

  sram_lane_rdcap #(.LANES(LANES), .LANE_W(LANE_W)) rdcap_i (
    .clk     (clk),
    .rst_n   (rst_sync_q),
    .capture (capture),
    .org     (org_q),
    .lsb     (lsb_q),
    .dq_in   (mem_dq_in),
    .rdata_q (rsp_rdata)
  );

  assign mem_addr   = paddr_q;
  assign mem_cs_n   = ~(sel_q & {LANES{cs_act}});
  assign mem_we_n   = ~(wmask_q & {LANES{we_act}});
  assign mem_oe_n   = ~oe_act;
  assign mem_dq_out = wdata_q;
  assign mem_dq_oe  = drive;

endmodule

// File: rtl/sram_lane_ctrl_chk.sv
`timescale 1ns/1ps
module sram_lane_ctrl_chk
  import sram_lane_pkg::*;
#(
  parameter int LANES   = 4,
  parameter int LANE_W  = 8,
  parameter int PADDR_W = 17,
  parameter int unsigned CLK_PS  = 5000,
  parameter int unsigned T_WC_PS = 15000,
  parameter int unsigned T_WP_PS = 13000,
  parameter int unsigned T_DW_PS = 10000,
  parameter int unsigned T_RC_PS = 15000,
  parameter int unsigned T_OE_PS = 10000,
  parameter int unsigned T_HZ_PS = 8000,
  localparam int DATA_W = LANES * LANE_W
) (
  input logic               clk,
  input logic               rst_n,
  input logic               req_ready,
  input logic               rsp_done,
  input logic [PADDR_W-1:0] mem_addr,
  input logic [LANES-1:0]   mem_cs_n,
  input logic [LANES-1:0]   mem_we_n,
  input logic               mem_oe_n,
  input logic [DATA_W-1:0]  mem_dq_out,
  input logic               mem_dq_oe
);

  localparam int unsigned WP_CYC = strobe_cycles(CLK_PS, T_WP_PS, T_DW_PS, T_WC_PS);
  localparam int unsigned RD_CYC = access_cycles(CLK_PS, T_RC_PS, T_OE_PS);

  logic [15:0] we_run, oe_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      we_run <= '0;
      oe_run <= '0;
    end else begin
      we_run <= (|(~mem_we_n)) ? we_run + 16'd1 : 16'd0;
      oe_run <= (!mem_oe_n)    ? oe_run + 16'd1 : 16'd0;
    end
  end

  p_no_drive_on_read_r9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dq_oe |-> mem_oe_n);

  p_oe_we_exclusive_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_oe_n |-> (&mem_we_n));

  p_we_under_cs_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (|(~mem_we_n)) |-> (((~mem_we_n) & mem_cs_n) == '0));

  p_strobe_width_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ((&mem_we_n) && (we_run != 16'd0)) |-> (we_run == 16'(WP_CYC)));

  p_strobe_stable_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ((|(~mem_we_n)) && (|(~$past(mem_we_n)))) |-> ($stable(mem_addr) && $stable(mem_dq_out) && mem_dq_oe));

  p_read_width_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_oe_n && (oe_run != 16'd0)) |-> (oe_run == 16'(RD_CYC)));

  p_turnaround_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_oe_n) |-> (!mem_dq_oe && !req_ready));

  p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |=> !rsp_done);

  p_ready_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> ((&mem_cs_n) && mem_oe_n && !mem_dq_oe));

endmodule

bind sram_lane_ctrl sram_lane_ctrl_chk #(
  .LANES(LANES), .LANE_W(LANE_W), .PADDR_W(PADDR_W),
  .CLK_PS(CLK_PS), .T_WC_PS(T_WC_PS), .T_WP_PS(T_WP_PS), .T_DW_PS(T_DW_PS),
  .T_RC_PS(T_RC_PS), .T_OE_PS(T_OE_PS), .T_HZ_PS(T_HZ_PS)
) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_ready  (req_ready),
  .rsp_done   (rsp_done),
  .mem_addr   (mem_addr),
  .mem_cs_n   (mem_cs_n),
  .mem_we_n   (mem_we_n),
  .mem_oe_n   (mem_oe_n),
  .mem_dq_out (mem_dq_out),
  .mem_dq_oe  (mem_dq_oe)
);

// File: tb/sram_lane_ctrl_tb_top.sv
`timescale 1ns/1ps
module sram_lane_ctrl_tb_top;

  localparam int CLK   = 5000;
  localparam int T_WC  = 15000, T_WP = 13000, T_DW = 10000;
  localparam int T_RC  = 15000, T_OE = 10000, T_HZ = 8000;
  localparam int MDEP  = 64;

  function automatic int cdiv(input int t);
    return (t + CLK - 1) / CLK;
  endfunction
  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  localparam int EXP_WP = imax(imax(cdiv(T_WP), cdiv(T_DW)), cdiv(T_WC) - 1);
  localparam int EXP_RD = imax(cdiv(T_RC), cdiv(T_OE));
  localparam int EXP_TA = cdiv(T_HZ);

  logic        clk, rst_n;
  logic [1:0]  org_mode;
  logic        req_valid, req_ready, req_write;
  logic [18:0] req_addr;
  logic [31:0] req_wdata;
  logic [3:0]  req_be;
  logic        rsp_done;
  logic [31:0] rsp_rdata;
  logic [16:0] mem_addr;
  logic [3:0]  mem_cs_n, mem_we_n;
  logic        mem_oe_n;
  logic [31:0] mem_dq_out;
  logic        mem_dq_oe;
  logic [31:0] mem_dq_in;

  int checks = 0;
  int errors = 0;

  sram_lane_ctrl #(
    .CLK_PS(CLK), .T_WC_PS(T_WC), .T_WP_PS(T_WP), .T_DW_PS(T_DW),
    .T_RC_PS(T_RC), .T_OE_PS(T_OE), .T_HZ_PS(T_HZ)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .org_mode(org_mode),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
    .rsp_done(rsp_done), .rsp_rdata(rsp_rdata),
    .mem_addr(mem_addr), .mem_cs_n(mem_cs_n), .mem_we_n(mem_we_n),
    .mem_oe_n(mem_oe_n), .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe),
    .mem_dq_in(mem_dq_in)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // bench stand-in for the four banks
  logic [7:0] mem_m [4][MDEP];
  logic [7:0] exp_m [4][MDEP];

  always @(negedge clk) begin
    for (int l = 0; l < 4; l++)
      if (!mem_cs_n[l] && !mem_we_n[l])
        mem_m[l][mem_addr[5:0]] <= mem_dq_out[l*8 +: 8];
  end

  always_comb begin
    for (int l = 0; l < 4; l++)
      mem_dq_in[l*8 +: 8] = (!mem_cs_n[l] && !mem_oe_n && mem_we_n[l]) ? mem_m[l][mem_addr[5:0]] : 8'hA5;
  end

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic string mtag(input logic [1:0] md);
    return (md == 2'b00) ? "R2" : (md == 2'b01) ? "R4" : "R5";
  endfunction

  function automatic logic [3:0] exp_lanes(input logic [1:0] md, input logic [18:0] la);
    if (md == 2'b00) return 4'b1111;
    if (md == 2'b01) return la[0] ? 4'b1100 : 4'b0011;
    return 4'b0001 << la[1:0];
  endfunction

  function automatic logic [16:0] exp_paddr(input logic [1:0] md, input logic [18:0] la);
    if (md == 2'b00) return la[16:0];
    if (md == 2'b01) return la[17:1];
    return la[18:2];
  endfunction

  task automatic exp_write(input logic [1:0] md, input logic [18:0] la,
                           input logic [31:0] wd, input logic [3:0] be);
    int pa;
    pa = int'(exp_paddr(md, la));
    if (md == 2'b00) begin
      for (int l = 0; l < 4; l++) if (be[l]) exp_m[l][pa] = wd[l*8 +: 8];
    end else if (md == 2'b01) begin
      exp_m[la[0]*2][pa]     = wd[7:0];
      exp_m[la[0]*2 + 1][pa] = wd[15:8];
    end else begin
      exp_m[la[1:0]][pa] = wd[7:0];
    end
  endtask

  function automatic logic [31:0] exp_read(input logic [1:0] md, input logic [18:0] la);
    int pa;
    pa = int'(exp_paddr(md, la));
    if (md == 2'b00) return {exp_m[3][pa], exp_m[2][pa], exp_m[1][pa], exp_m[0][pa]};
    if (md == 2'b01) return {16'h0, exp_m[la[0]*2 + 1][pa], exp_m[la[0]*2][pa]};
    return {24'h0, exp_m[la[1:0]][pa]};
  endfunction

  task automatic access(input bit wr, input logic [1:0] md, input logic [18:0] la,
                        input logic [31:0] wd, input logic [3:0] be);
    int lat, turn;
    int wecnt [4];
    logic [3:0] cs_seen, exp_cs, exp_we;
    bit drive_bad, wdata_bad, addr_bad, we_bad;
    logic [31:0] rd;
    for (int l = 0; l < 4; l++) wecnt[l] = 0;
    cs_seen = '0; drive_bad = 0; wdata_bad = 0; addr_bad = 0; we_bad = 0;
    exp_cs = exp_lanes(md, la);
    exp_we = wr ? ((md == 2'b00) ? be : exp_cs) : 4'b0000;

    @(negedge clk);
    while (!req_ready) @(negedge clk);
    org_mode = md; req_write = wr; req_addr = la; req_wdata = wd; req_be = be; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    lat = 1;
    while (1) begin
      for (int l = 0; l < 4; l++) begin
        if (!mem_cs_n[l]) cs_seen[l] = 1'b1;
        if (!mem_we_n[l]) begin
          wecnt[l]++;
          if (!mem_dq_oe) wdata_bad = 1;
        end
      end
      if (mem_dq_oe && !mem_oe_n) drive_bad = 1;
      if (!mem_oe_n && !(&mem_we_n)) drive_bad = 1;
      if (!(&mem_cs_n) && mem_addr != exp_paddr(md, la)) addr_bad = 1;
      if (rsp_done || lat > 60) break;
      @(negedge clk);
      lat++;
    end
    rd = rsp_rdata;
    if (wr) check(req_ready, "R10", "ready at write done", 32'(req_ready), 32'd1);
    @(negedge clk);
    check(!rsp_done, "R10", "done one cycle", 32'(rsp_done), 32'd0);
    turn = 1;
    if (!wr) begin
      while (!req_ready && turn < 60) begin
        if (mem_dq_oe) drive_bad = 1;
        @(negedge clk);
        turn++;
      end
      check(turn == EXP_TA, "R8", "turnaround cycles", 32'(turn), 32'(EXP_TA));
    end

    if (wr) check(lat == EXP_WP + 2, "R6", "write done latency", 32'(lat), 32'(EXP_WP + 2));
    else    check(lat == EXP_RD + 1, "R7", "read done latency", 32'(lat), 32'(EXP_RD + 1));
    check(cs_seen == exp_cs, mtag(md), "chip select lanes", 32'(cs_seen), 32'(exp_cs));
    check(!addr_bad, mtag(md), "physical address", 32'(mem_addr), 32'(exp_paddr(md, la)));
    for (int l = 0; l < 4; l++)
      if (wecnt[l] != (exp_we[l] ? EXP_WP : 0)) we_bad = 1;
    check(!we_bad, (md == 2'b00 && wr) ? "R3" : "R6", "write strobe lanes/width",
          {wecnt[3][7:0], wecnt[2][7:0], wecnt[1][7:0], wecnt[0][7:0]}, 32'(exp_we));
    check(!drive_bad, "R9", "bus drive while output enabled", 32'(drive_bad), 32'd0);
    if (wr) begin
      check(!wdata_bad, "R6", "bus driven during strobe", 32'(wdata_bad), 32'd0);
      exp_write(md, la, wd, be);
    end else begin
      check(rd == exp_read(md, la), mtag(md), "read data", rd, exp_read(md, la));
    end
  endtask

  // watchdog
  initial begin
    for (int c = 0; c < 150000; c++) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int l = 0; l < 4; l++)
      for (int a = 0; a < MDEP; a++) begin
        mem_m[l][a] = 8'h00;
        exp_m[l][a] = 8'h00;
      end
    rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; org_mode = 2'b00;
    req_addr = '0; req_wdata = '0; req_be = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    check(req_ready == 1'b1, "R1", "ready", 32'(req_ready), 32'd1);
    check(mem_cs_n == 4'hF, "R1", "cs_n", 32'(mem_cs_n), 32'hF);
    check(mem_we_n == 4'hF, "R1", "we_n", 32'(mem_we_n), 32'hF);
    check(mem_oe_n == 1'b1, "R1", "oe_n", 32'(mem_oe_n), 32'd1);
    check(mem_dq_oe == 1'b0, "R1", "dq_oe", 32'(mem_dq_oe), 32'd0);
    check(rsp_done == 1'b0, "R1", "done", 32'(rsp_done), 32'd0);

    // R2: full-word sweep
    for (int a = 0; a < 64; a++)
      access(1'b1, 2'b00, 19'(a), 32'(a) * 32'h9E3779B1 + 32'h01234567, 4'hF);
    for (int a = 0; a < 64; a++)
      access(1'b0, 2'b00, 19'(a), 32'h0, 4'h0);

    // R3: every byte-enable mask
    for (int a = 0; a < 16; a++)
      access(1'b1, 2'b00, 19'(a), ~(32'(a) * 32'h01010101), 4'(a));
    for (int a = 0; a < 16; a++)
      access(1'b0, 2'b00, 19'(a), 32'h0, 4'h0);

    // R4: halfword sweep, upper write bits are junk
    for (int a = 0; a < 128; a++)
      access(1'b1, 2'b01, 19'(a), {16'hDEAD, 16'(a * 16'h1357 + 7)}, 4'h0);
    for (int a = 0; a < 128; a++)
      access(1'b0, 2'b01, 19'(a), 32'h0, 4'h0);

    // R5: byte sweep, both 8-bit encodings alternated
    for (int a = 0; a < 256; a++)
      access(1'b1, (a % 2 == 0) ? 2'b10 : 2'b11, 19'(a), {24'hBEEF5A, 8'(a * 7 + 3)}, 4'hF);
    for (int a = 0; a < 256; a++)
      access(1'b0, (a % 3 == 0) ? 2'b11 : 2'b10, 19'(a), 32'h0, 4'h0);

    // R2 lane order seen through the word view after byte writes
    for (int a = 0; a < 64; a++)
      access(1'b0, 2'b00, 19'(a), 32'h0, 4'h0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule